// File: doc/BRIEF.md
# Block Translation Entry Matcher

This block maps a 32-bit effective address onto a real page address by comparing it against a small bank of block translation entries. Each entry is a pair of 32-bit registers. The upper register names the effective block and the privilege states in which the entry may be used. The lower register names the real block and its access rights. There are two banks, one for instruction fetches and one for data accesses. A fetch searches only the instruction bank; every other access searches the data bank.

An entry's block size is set by an 11-bit block-length field. This field clears address bits 27:17 from the compare mask, so a block can be anywhere from 128 KB to 256 MB. Address bits that fall outside the mask pass straight from the effective address into the real address. When no entry matches, the block signals a miss so that the surrounding translation logic can fall back to segment translation.

Software loads the entry registers through a single write port. A lookup is presented with a valid strobe, and its result is registered one clock later.

Top module: `bat_matcher`

## Requirements
- R1: After reset every entry register of both banks reads as zero. No lookup can hit until an entry is written.
- R2: An entry may take part in a lookup only if it is enabled for the current privilege. In user state this means bit 0 of its upper register is set. In supervisor state it means bit 1 of its upper register is set.
- R3: The compare mask starts from the page-index field of the upper register, bits 31:17. The block-length field, upper bits 12:2, is shifted left by 15 and every bit it covers is removed from the mask. An entry matches when (ea AND mask) equals the upper register's bits 31:17, with the rest of that comparison value zero.
- R4: On a hit, the real page output is bits 31:12 of ((lower AND mask) OR (ea AND NOT mask)). The page offset, ea bits 11:0, is not part of the output.
- R5: On a hit, the permission output res_perm (bit 0 read, bit 1 write, bit 2 execute) comes from lower bits 1:0. The value 0 grants nothing. The values 1 and 3 grant read and execute. The value 2 grants read, write and execute.
- R6: When lk_fetch is 1, only the instruction bank (wr_side = 1) is searched. When lk_fetch is 0, only the data bank (wr_side = 0) is searched.
- R7: Entries are examined from index 0 upward, and the lowest-indexed matching entry decides the result.
- R8: When no entry matches, res_hit is 0, and res_page and res_perm are both zero.
- R9: A write stores wr_data into the bank named by wr_side, the entry named by wr_idx, and the upper register if wr_hi is 1 or the lower register otherwise. A lookup in the same cycle as a write sees the old contents. Lookups from the next cycle onward see the new contents.
- R10: res_valid is asserted in the cycle after lk_valid, and res_hit, res_page and res_perm in that cycle belong to that lookup. When lk_valid was 0, res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Entry register write strobe |
| wr_side | input | 1 | Bank to write: 1 for instruction, 0 for data |
| wr_idx | input | 2 | Entry index to write |
| wr_hi | input | 1 | Register to write: 1 for upper, 0 for lower |
| wr_data | input | 32 | Value to write |
| lk_valid | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_fetch | input | 1 | 1 for an instruction fetch |
| lk_user | input | 1 | 1 for user (problem) state |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_hit | output | 1 | An entry matched |
| res_page | output | 20 | Real page number, address bits 31:12 |
| res_perm | output | 3 | Permission vector: read, write, execute |

## Verification
The bench builds the block with its default four entries per bank and 4 KB pages. With only four entries, a random mix of writes and lookups quickly produces overlapping blocks, so the first-match order of R7 is exercised often. The block-length values used include the extremes (no bits and all eleven bits) as well as sparse patterns, which covers every width of mask-controlled pass-through in R3 and R4. The bench reaches every privilege and bank combination and places writes in the same cycle as lookups to exercise R9.

// File: rtl/bat_pkg.sv
`timescale 1ns/1ps
package bat_pkg;
  localparam int EA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int PG_W      = EA_W - PAGE_BITS;
  localparam int IDX_LO    = 17;
  localparam int BL_LO     = 2;
  localparam int BL_W      = 11;
  localparam int BL_SHIFT  = 15;
  localparam int PERM_W    = 3;

  localparam logic [EA_W-1:0] IDX_FIELD = {{(EA_W-IDX_LO){1'b1}}, {IDX_LO{1'b0}}};

  typedef struct packed {
    logic [EA_W-1:0] up;
    logic [EA_W-1:0] lo;
  } bat_ent_t;

  // Entry enable for the current privilege: bit 0 user, bit 1 supervisor.
  function automatic logic bat_usable(input logic [EA_W-1:0] up, input logic user);
    return user ? up[0] : up[1];
  endfunction

  // Compare mask: the index field minus the length bits moved up by 15.
  function automatic logic [EA_W-1:0] bat_mask(input logic [EA_W-1:0] up);
    logic [EA_W-1:0] len;
    len = {{(EA_W-BL_W){1'b0}}, up[BL_LO +: BL_W]} << (BL_LO + BL_SHIFT);
    return IDX_FIELD & ~len;
  endfunction

  function automatic logic bat_match(input logic [EA_W-1:0] ea,
                                     input logic [EA_W-1:0] up,
                                     input logic [EA_W-1:0] mask);
    return (ea & mask) == (up & IDX_FIELD);
  endfunction

  function automatic logic [PG_W-1:0] bat_rpage(input logic [EA_W-1:0] ea,
                                                input logic [EA_W-1:0] lo,
                                                input logic [EA_W-1:0] mask);
    logic [EA_W-1:0] ra;
    ra = (lo & mask) | (ea & ~mask);
    return ra[EA_W-1:PAGE_BITS];
  endfunction

  // {exec, write, read}
  function automatic logic [PERM_W-1:0] bat_perm(input logic [1:0] pp);
    case (pp)
      2'd0:    return 3'b000;
      2'd2:    return 3'b111;
      default: return 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/bat_regfile.sv
`timescale 1ns/1ps
module bat_regfile
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_side,
  input  logic [IW-1:0]   wr_idx,
  input  logic            wr_hi,
  input  logic [EA_W-1:0] wr_data,
  output bat_ent_t        ibank [NUM_ENT],
  output bat_ent_t        dbank [NUM_ENT]
);
  for (genvar s = 0; s < 2; s++) begin : g_side
    for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      bat_ent_t ent_q;
      logic     sel_w;
      assign sel_w = wr_en && (wr_side == 1'(s)) && (wr_idx == IW'(e));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          ent_q <= '0;
        end else if (sel_w) begin
          if (wr_hi) ent_q.up <= wr_data;
          else       ent_q.lo <= wr_data;
        end
      end
      if (s == 1) begin : g_i
        assign ibank[e] = ent_q;
      end else begin : g_d
        assign dbank[e] = ent_q;
      end
    end
  end
endmodule

// File: rtl/bat_entry_cmp.sv
`timescale 1ns/1ps
module bat_entry_cmp
  import bat_pkg::*;
(
  input  logic [EA_W-1:0]   ea,
  input  logic              user,
  input  bat_ent_t          ent,
  output logic              hit,
  output logic [PG_W-1:0]   page,
  output logic [PERM_W-1:0] perm
);
  logic [EA_W-1:0] mask_w;
  logic            usable_w;
  logic            match_w;

  assign mask_w   = bat_mask(ent.up);
  assign usable_w = bat_usable(ent.up, user);
  assign match_w  = bat_match(ea, ent.up, mask_w);
  assign hit      = usable_w && match_w;
  assign page     = bat_rpage(ea, ent.lo, mask_w);
  assign perm     = bat_perm(ent.lo[1:0]);
endmodule

// File: rtl/bat_first_sel.sv
`timescale 1ns/1ps
module bat_first_sel
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4
)(
  input  logic [NUM_ENT-1:0] hit_vec,
  input  logic [PG_W-1:0]    page_in [NUM_ENT],
  input  logic [PERM_W-1:0]  perm_in [NUM_ENT],
  output logic [NUM_ENT-1:0] sel,
  output logic               any,
  output logic [PG_W-1:0]    page,
  output logic [PERM_W-1:0]  perm
);
  always_comb begin
    sel  = '0;
    page = '0;
    perm = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        sel     = '0;
        sel[i]  = 1'b1;
        page    = page_in[i];
        perm    = perm_in[i];
      end
    end
  end
  assign any = |hit_vec;
endmodule

// File: rtl/bat_matcher.sv
`timescale 1ns/1ps
module bat_matcher
  import bat_pkg::*;
#(
  parameter int NUM_ENT = 4,
  localparam int IW = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_side,
  input  logic [IW-1:0]     wr_idx,
  input  logic              wr_hi,
  input  logic [EA_W-1:0]   wr_data,
  input  logic              lk_valid,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic              lk_fetch,
  input  logic              lk_user,
  output logic              res_valid,
  output logic              res_hit,
  output logic [PG_W-1:0]   res_page,
  output logic [PERM_W-1:0] res_perm
);
  bat_ent_t ibank [NUM_ENT];
  bat_ent_t dbank [NUM_ENT];

  bat_regfile #(.NUM_ENT(NUM_ENT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
    .ibank(ibank), .dbank(dbank)
  );

  logic [NUM_ENT-1:0] hit_vec;
  logic [PG_W-1:0]    page_vec [NUM_ENT];
  logic [PERM_W-1:0]  perm_vec [NUM_ENT];

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    bat_ent_t act_ent;
    assign act_ent = lk_fetch ? ibank[e] : dbank[e];
    bat_entry_cmp u_cmp (
      .ea(lk_ea), .user(lk_user), .ent(act_ent),
      .hit(hit_vec[e]), .page(page_vec[e]), .perm(perm_vec[e])
    );
  end

  logic [NUM_ENT-1:0] sel_w;
  logic               any_w;
  logic [PG_W-1:0]    page_w;
  logic [PERM_W-1:0]  perm_w;

  bat_first_sel #(.NUM_ENT(NUM_ENT)) u_sel (
    .hit_vec(hit_vec), .page_in(page_vec), .perm_in(perm_vec),
    .sel(sel_w), .any(any_w), .page(page_w), .perm(perm_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_page  <= '0;
      res_perm  <= '0;
    end else begin
      res_valid <= lk_valid;
      res_hit   <= lk_valid && any_w;
      res_page  <= (lk_valid && any_w) ? page_w : '0;
      res_perm  <= (lk_valid && any_w) ? perm_w : '0;
    end
  end

  // Selection picks at most one entry, and only one that matched (R7).
  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_w));
  p_sel_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w & ~hit_vec) == '0);
  p_sel_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    any_w |-> $countones(sel_w) == 1);
  // A miss leaves page and permissions at zero (R8).
  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_page == '0 && res_perm == '0));
  // Write permission always comes with read and execute (R5).
  p_write_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_perm[1] |-> (res_perm[0] && res_perm[2]));
  // Result strobe follows the request by one cycle (R10).
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  p_idle_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!res_valid && !res_hit));
endmodule

// File: tb/bat_matcher_test.sv
`timescale 1ns/1ps
module bat_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_side = 1'b0, wr_hi = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        lk_valid = 1'b0, lk_fetch = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_ea = '0;
  logic        res_valid, res_hit;
  logic [19:0] res_page;
  logic [2:0]  res_perm;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state: [side][entry], side 1 = instruction
  bit [31:0] mu [2][4];
  bit [31:0] ml [2][4];

  bat_matcher uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_side(wr_side),
    .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_fetch(lk_fetch), .lk_user(lk_user),
    .res_valid(res_valid), .res_hit(res_hit), .res_page(res_page), .res_perm(res_perm)
  );

  always #2 clk = ~clk;

  task automatic ref_lookup(input bit [31:0] ea, input bit fetch, input bit user,
                            output bit h, output bit [19:0] pg, output bit [2:0] pm);
    h = 0; pg = 0; pm = 0;
    for (int i = 0; i < 4; i++) begin
      bit [31:0] u, l, m, ra;
      bit ok;
      if (h) continue;
      u = mu[fetch ? 1 : 0][i];
      l = ml[fetch ? 1 : 0][i];
      ok = user ? u[0] : u[1];
      m = 32'hFFFE_0000;
      for (int b = 17; b < 28; b++) if (u[b-15]) m[b] = 1'b0;
      if (ok && ((ea & m) == (u & 32'hFFFE_0000))) begin
        h = 1;
        ra = (l & m) | (ea & ~m);
        pg = ra[31:12];
        case (l[1:0])
          2'b00: pm = 3'b000;
          2'b10: pm = 3'b111;
          default: pm = 3'b101;
        endcase
      end
    end
  endtask

  task automatic check(input string tag, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: inputs already driven; compare at posedge + 1.
  task automatic cyc(input string tag);
    bit ev, eh;
    bit [19:0] ep;
    bit [2:0] em;
    @(posedge clk);
    ev = lk_valid;
    eh = 0; ep = 0; em = 0;
    if (lk_valid) ref_lookup(lk_ea, lk_fetch, lk_user, eh, ep, em);
    if (wr_en) begin
      if (wr_hi) mu[wr_side][wr_idx] = wr_data;
      else       ml[wr_side][wr_idx] = wr_data;
    end
    #1;
    check(tag, res_valid === ev, "res_valid", 32'(res_valid), 32'(ev));
    if (ev) begin
      check(tag, res_hit === eh, "res_hit", 32'(res_hit), 32'(eh));
      check(tag, res_page === ep, "res_page", 32'(res_page), 32'(ep));
      check(tag, res_perm === em, "res_perm", 32'(res_perm), 32'(em));
    end
    @(negedge clk);
    wr_en = 0;
    lk_valid = 0;
  endtask

  task automatic wr(input bit side, input bit [1:0] idx, input bit hi, input bit [31:0] d,
                    input string tag);
    wr_en = 1; wr_side = side; wr_idx = idx; wr_hi = hi; wr_data = d;
    cyc(tag);
  endtask

  task automatic look(input bit [31:0] ea, input bit fetch, input bit user, input string tag);
    lk_valid = 1; lk_ea = ea; lk_fetch = fetch; lk_user = user;
    cyc(tag);
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) for (int i = 0; i < 4; i++) begin mu[s][i] = 0; ml[s][i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: nothing hits after reset
    look(32'h0000_0000, 0, 0, "R1");
    look(32'h0000_0000, 1, 1, "R1");
    // data entry 0: index 0x1000_0000, 128 KB, user only, pp=2
    wr(0, 0, 1, 32'h1000_0001, "R9");
    wr(0, 0, 0, 32'h8000_0002, "R9");
    look(32'h1001_F345, 0, 1, "R3");   // hit, offset bits pass through (R4)
    look(32'h1002_0000, 0, 1, "R3");   // just outside block: miss (R8)
    look(32'h1000_0000, 0, 0, "R2");   // supervisor: not enabled
    look(32'h1000_0000, 1, 1, "R6");   // fetch searches instruction bank
    // instruction entry 2: 256 MB, supervisor only, pp=1
    wr(1, 2, 1, 32'h3000_1FFE, "R9");
    wr(1, 2, 0, 32'hA000_0001, "R9");
    look(32'h3ABC_D123, 1, 0, "R4");
    look(32'h3ABC_D123, 1, 1, "R2");
    look(32'h3ABC_D123, 0, 0, "R6");
    // overlap: instr entry 1 covers same region with pp=0
    wr(1, 1, 1, 32'h3000_1FFF, "R9");
    wr(1, 1, 0, 32'h5000_0000, "R9");
    look(32'h3000_0000, 1, 0, "R7");
    // pp=3 on data entry 3, sparse length bits
    wr(0, 3, 1, 32'hC000_0146, "R9");
    wr(0, 3, 0, 32'hE000_0003, "R9");
    look(32'hC0A4_5000, 0, 0, "R5");
    look(32'hC0A6_5000, 0, 1, "R5");
    // same-cycle write and lookup: old contents used (R9)
    wr_en = 1; wr_side = 0; wr_idx = 0; wr_hi = 1; wr_data = 32'h0;
    lk_valid = 1; lk_ea = 32'h1000_0000; lk_fetch = 0; lk_user = 1;
    cyc("R9");
    look(32'h1000_0000, 0, 1, "R9");
    // R10: idle cycle
    cyc("R10");
    // random sweep
    for (int n = 0; n < 4000; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        bit [31:0] d;
        bit [10:0] bl;
        case ($urandom_range(0, 3))
          0: bl = 11'h000;
          1: bl = 11'h7FF;
          2: bl = 11'h00F;
          default: bl = 11'($urandom);
        endcase
        d = {$urandom_range(0, 7) == 0 ? 15'($urandom) : {3'($urandom), 12'h0}, 2'b0, bl, 2'($urandom)};
        if ($urandom_range(0, 1) == 1) d = {d[31:2], 2'($urandom)};
        wr_en = 1; wr_side = 1'($urandom); wr_idx = 2'($urandom);
        wr_hi = 1'($urandom); wr_data = d;
      end
      if ($urandom_range(0, 3) != 0) begin
        bit [31:0] a;
        a = {mu[$urandom_range(0, 1)][$urandom_range(0, 3)][31:17], 17'($urandom)};
        if ($urandom_range(0, 3) == 0) a[27:17] = 11'($urandom);
        lk_valid = 1; lk_ea = a; lk_fetch = 1'($urandom); lk_user = 1'($urandom);
      end
      cyc("R3");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule